// File: doc/BRIEF.md
# UART Low-Power State Controller

This block decides when one UART channel drops into a low-power state and when it comes back. Its inputs are the sleep-enable register bit, a power-save strap, the channel's combined pending-interrupt flag, the serial receive line and the four active-low modem status lines. It drives an oscillator enable, a core clock enable, a host-bus isolation enable and a wake-up interrupt request. It also takes the host interface's modem-status-read strobe, its interrupt-status-read strobe and the wake-interrupt enable bit from the FIFO control register.

There are two depths of low power. In plain sleep the oscillator is stopped. In the isolated state the oscillator is also stopped, and the host bus is cut off inside the block, so register strobes have no effect. The block wakes on a falling edge of the receive line, on any change of a modem line, or when the configuration or an interrupt calls for it. After a wake the oscillator restarts, and the core clock returns only once a programmable warm-up count has run out. If the wake came from isolation while isolation is still configured, the block goes back into isolation by itself. It does so once the host has read the modem status and no interrupt is pending.

Top module: `uart_lp_ctrl`

## Requirements
- R1: After reset, osc_en_o=1, clk_en_o=1, bus_iso_o=0 and wake_irq_o=0.
- R2: While awake and running, the channel sleeps when sleep_en_i=1 and irq_pend_i=0: osc_en_o and clk_en_o fall one cycle after that condition is sampled. A pending interrupt keeps the channel running.
- R3: In plain sleep, sleep_en_i=0, irq_pend_i=1 or a wake event starts warm-up on the next cycle.
- R4: In plain sleep with psave_i=1, the channel moves to the isolated state on the next cycle, with bus_iso_o=1 and osc_en_o=0.
- R5: While isolated, pulses on msr_rd_i and isr_rd_i have no effect: bus_iso_o stays 1 and wake_irq_o keeps its value.
- R6: The receive line and each modem line pass through two synchronizing flops. A wake event is a 1-to-0 step of the synchronized receive line, or any change of a synchronized modem bit. A 0-to-1 step of the receive line is not a wake event. An input change sampled at edge k takes effect on the state at edge k+2.
- R7: Warm-up holds osc_en_o=1 and clk_en_o=0 for exactly STARTUP_CYCLES cycles, then raises clk_en_o.
- R8: After a wake from isolation, if sleep_en_i=1 and psave_i=1 the channel runs until an msr_rd_i pulse has been seen and irq_pend_i=0. It then returns to isolation on the next cycle.
- R9: With sleep_en_i=0 or psave_i=0, the isolated state is left through warm-up and is not re-entered by itself.
- R10: wake_irq_o is set by a wake event that occurs in sleep or isolation, and only when wake_irq_en_i=1. It resets to disabled.
- R11: wake_irq_o clears one cycle after isr_rd_i is sampled outside isolation, or after wake_irq_en_i is sampled as 0. A clear wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en_i | input | 1 | Sleep-enable register bit |
| psave_i | input | 1 | Power-save strap |
| irq_pend_i | input | 1 | Any channel interrupt pending |
| rx_i | input | 1 | Serial receive line, idles high |
| modem_n_i | input | 4 | Active-low modem status lines |
| msr_rd_i | input | 1 | Modem status register read strobe |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| wake_irq_en_i | input | 1 | Wake-up interrupt enable bit |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | Core clock enable |
| bus_iso_o | output | 1 | Host bus isolation enable |
| wake_irq_o | output | 1 | Wake-up interrupt request |

## Verification
On every cycle the assertions check these relations between the outputs: isolation never coexists with a running oscillator, the clock enable never leads the oscillator, and a rising oscillator never comes with the clock already on. They also check that a pending interrupt never lets a running channel stop, that strap removal ends isolation, and that both wake-interrupt clears take effect. Only the bench's scenarios can show the rest: the exact warm-up length, the two-flop wake latency, and that a rising receive edge does not wake. The same holds for the automatic return to isolation, which must wait for both the status read and a quiet interrupt line, and for the strobes being ignored while isolated.

// File: rtl/uart_lp_pkg.sv
package uart_lp_pkg;

    localparam int MODEM_W = 4;
    localparam int LINE_W  = MODEM_W + 1;

    typedef enum logic [2:0] {
        LP_RUN  = 3'd0,
        LP_DOZE = 3'd1,
        LP_ISOL = 3'd2,
        LP_WARM = 3'd3,
        LP_HELD = 3'd4
    } lp_state_e;

    typedef struct packed {
        logic osc_en;
        logic clk_en;
        logic bus_iso;
    } lp_ctl_t;

    function automatic lp_ctl_t lp_decode(input lp_state_e s);
        lp_ctl_t c;
        c.osc_en  = !(s == LP_DOZE || s == LP_ISOL);
        c.clk_en  = (s == LP_RUN || s == LP_HELD);
        c.bus_iso = (s == LP_ISOL);
        return c;
    endfunction

endpackage

// File: rtl/uart_lp_sync.sv
module uart_lp_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] fall,
    output logic [W-1:0] chg
);
    for (genvar i = 0; i < W; i++) begin : g_line
        logic s1, s2, prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                prev <= 1'b1;
            end else begin
                s1   <= din[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign fall[i] = prev & ~s2;
        assign chg[i]  = prev ^ s2;
    end
endmodule

// File: rtl/uart_lp_fsm.sv
module uart_lp_fsm
    import uart_lp_pkg::*;
#(
    parameter int STARTUP_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep_en,
    input  logic      psave,
    input  logic      irq_pend,
    input  logic      wake_ev,
    input  logic      msr_rd,
    output lp_state_e state,
    output logic      low_pwr
);
    localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYCLES - 1);

    lp_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ret_q, ret_d;
    logic             seen_q, seen_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        ret_d  = ret_q;
        seen_d = seen_q;
        case (st_q)
            LP_RUN: begin
                if (sleep_en && !irq_pend) st_d = LP_DOZE;
            end
            LP_DOZE: begin
                if (!sleep_en || irq_pend || wake_ev) begin
                    st_d  = LP_WARM;
                    ret_d = 1'b0;
                    cnt_d = '0;
                end else if (psave) begin
                    st_d = LP_ISOL;
                end
            end
            LP_ISOL: begin
                if (!sleep_en || !psave) begin
                    st_d  = LP_WARM;
                    ret_d = 1'b0;
                    cnt_d = '0;
                end else if (wake_ev || irq_pend) begin
                    st_d  = LP_WARM;
                    ret_d = 1'b1;
                    cnt_d = '0;
                end
            end
            LP_WARM: begin
                if (cnt_q == CNT_LAST) begin
                    st_d   = ret_q ? LP_HELD : LP_RUN;
                    cnt_d  = '0;
                    seen_d = 1'b0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            LP_HELD: begin
                if (msr_rd) seen_d = 1'b1;
                if (!sleep_en || !psave) begin
                    st_d = LP_RUN;
                end else if ((seen_q || msr_rd) && !irq_pend) begin
                    st_d = LP_ISOL;
                end
            end
            default: st_d = LP_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= LP_RUN;
            cnt_q  <= '0;
            ret_q  <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            ret_q  <= ret_d;
            seen_q <= seen_d;
        end
    end

    assign state   = st_q;
    assign low_pwr = (st_q == LP_DOZE) || (st_q == LP_ISOL);
endmodule

// File: rtl/uart_lp_wirq.sv
module uart_lp_wirq (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic clr,
    input  logic set,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst)                 req <= 1'b0;
        else if (!enable || clr) req <= 1'b0;
        else if (set)            req <= 1'b1;
    end
endmodule

// File: rtl/uart_lp_ctrl.sv
module uart_lp_ctrl
    import uart_lp_pkg::*;
#(
    parameter int STARTUP_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep_en_i,
    input  logic               psave_i,
    input  logic               irq_pend_i,
    input  logic               rx_i,
    input  logic [MODEM_W-1:0] modem_n_i,
    input  logic               msr_rd_i,
    input  logic               isr_rd_i,
    input  logic               wake_irq_en_i,
    output logic               osc_en_o,
    output logic               clk_en_o,
    output logic               bus_iso_o,
    output logic               wake_irq_o
);
    logic [LINE_W-1:0] fall, chg;
    logic              wake_ev, low_pwr;
    lp_state_e         state;
    lp_ctl_t           ctl;
    logic              msr_gated, isr_gated;

    uart_lp_sync #(.W(LINE_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({modem_n_i, rx_i}),
        .fall(fall),
        .chg (chg)
    );

    assign wake_ev = fall[0] | (|chg[LINE_W-1:1]);

    assign ctl       = lp_decode(state);
    assign msr_gated = msr_rd_i & ~ctl.bus_iso;
    assign isr_gated = isr_rd_i & ~ctl.bus_iso;

    uart_lp_fsm #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .sleep_en(sleep_en_i),
        .psave   (psave_i),
        .irq_pend(irq_pend_i),
        .wake_ev (wake_ev),
        .msr_rd  (msr_gated),
        .state   (state),
        .low_pwr (low_pwr)
    );

    uart_lp_wirq u_wirq (
        .clk   (clk),
        .rst   (rst),
        .enable(wake_irq_en_i),
        .clr   (isr_gated),
        .set   (wake_ev & low_pwr),
        .req   (wake_irq_o)
    );

    assign osc_en_o  = ctl.osc_en;
    assign clk_en_o  = ctl.clk_en;
    assign bus_iso_o = ctl.bus_iso;
endmodule

// File: rtl/uart_lp_ctrl_chk.sv
module uart_lp_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic psave_i,
    input logic irq_pend_i,
    input logic isr_rd_i,
    input logic wake_irq_en_i,
    input logic osc_en_o,
    input logic clk_en_o,
    input logic bus_iso_o,
    input logic wake_irq_o
);
    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (osc_en_o && clk_en_o && !bus_iso_o && !wake_irq_o)); // R1
    AST_IRQ_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (rst)
        (clk_en_o && irq_pend_i) |=> osc_en_o); // R2
    AST_ISO_OSC_OFF: assert property (@(posedge clk) disable iff (rst)
        bus_iso_o |-> !osc_en_o); // R4
    AST_CLK_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
        clk_en_o |-> osc_en_o); // R7
    AST_WARM_BEFORE_CLK: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en_o) |-> !clk_en_o); // R7
    AST_STRAP_ENDS_ISO: assert property (@(posedge clk) disable iff (rst)
        (bus_iso_o && !psave_i) |=> !bus_iso_o); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !wake_irq_en_i |=> !wake_irq_o); // R11
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (isr_rd_i && !bus_iso_o) |=> !wake_irq_o); // R11
endmodule

bind uart_lp_ctrl uart_lp_ctrl_chk u_chk (.*);

// File: tb/uart_lp_ctrl_tb.sv
module uart_lp_ctrl_tb;
    localparam int SU = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_en = 0, psave = 0, irq = 0, rx = 1;
    logic [3:0] modem = 4'hF;
    logic       msr_rd = 0, isr_rd = 0, wen = 0;
    logic       osc_en, clk_en, bus_iso, wake_irq;

    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uart_lp_ctrl #(.STARTUP_CYCLES(SU)) u_dut (
        .clk(clk), .rst(rst), .sleep_en_i(sleep_en), .psave_i(psave),
        .irq_pend_i(irq), .rx_i(rx), .modem_n_i(modem), .msr_rd_i(msr_rd),
        .isr_rd_i(isr_rd), .wake_irq_en_i(wen), .osc_en_o(osc_en),
        .clk_en_o(clk_en), .bus_iso_o(bus_iso), .wake_irq_o(wake_irq)
    );

    // behavioural reference: 0 run, 1 sleep, 2 isolated, 3 warm-up, 4 held awake
    int        mst, mcnt;
    bit        mret, mseen, mwirq;
    logic [4:0] hist[$];

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mcnt = 0; mret = 0; mseen = 0; mwirq = 0;
            hist = '{5'h1F, 5'h1F, 5'h1F};
        end else begin
            bit ev, iso, msr_ok;
            ev  = (hist[2][0] && !hist[1][0]) || (hist[2][4:1] != hist[1][4:1]);
            iso = (mst == 2);
            msr_ok = msr_rd && !iso;
            if (!wen || (isr_rd && !iso)) mwirq = 0;
            else if (ev && (mst == 1 || mst == 2)) mwirq = 1;
            case (mst)
                0: if (sleep_en && !irq) mst = 1;
                1: if (!sleep_en || irq || ev) begin mst = 3; mret = 0; mcnt = 0; end
                   else if (psave) mst = 2;
                2: if (!sleep_en || !psave) begin mst = 3; mret = 0; mcnt = 0; end
                   else if (ev || irq) begin mst = 3; mret = 1; mcnt = 0; end
                3: begin
                    mcnt++;
                    if (mcnt == SU) begin mst = mret ? 4 : 0; mseen = 0; end
                end
                default: begin
                    if (!sleep_en || !psave) mst = 0;
                    else if ((mseen || msr_ok) && !irq) mst = 2;
                    if (msr_ok) mseen = 1;
                end
            endcase
            hist.push_front({modem, rx});
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 osc_en model", osc_en, !(mst == 1 || mst == 2));
            chk("R7 clk_en model", clk_en, (mst == 0 || mst == 4));
            chk("R4 bus_iso model", bus_iso, (mst == 2));
            chk("R10 wake_irq model", wake_irq, mwirq);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(4);
        rst = 0;
        step(1);
        chk("R1 osc", osc_en, 1); chk("R1 clk", clk_en, 1);
        chk("R1 iso", bus_iso, 0); chk("R1 wirq", wake_irq, 0);

        // R2: pending interrupt keeps running, then sleep
        sleep_en = 1; irq = 1; step(4);
        chk("R2 awake with irq", osc_en, 1);
        irq = 0; step(3);
        chk("R2 sleep osc", osc_en, 0); chk("R2 sleep clk", clk_en, 0);
        chk("R2 plain sleep no iso", bus_iso, 0);

        // R3 + R7: irq wakes, warm-up length
        irq = 1; step(2);
        chk("R3 irq wake osc", osc_en, 1); chk("R7 warm clk off", clk_en, 0);
        step(SU);
        chk("R7 clk back", clk_en, 1);
        irq = 0; step(3);
        chk("R2 sleep again", osc_en, 0);
        sleep_en = 0; step(3);
        chk("R3 disable wakes", osc_en, 1);
        step(SU + 2);

        // R4 isolation
        wen = 1; psave = 1; sleep_en = 1; step(4);
        chk("R4 isolated", bus_iso, 1);
        // R5 strobes ignored
        msr_rd = 1; isr_rd = 1; step(1); msr_rd = 0; isr_rd = 0; step(2);
        chk("R5 iso kept", bus_iso, 1);
        // R6 modem change wakes, R10 sets request
        modem[2] = 0; step(4);
        chk("R6 modem wake", osc_en, 1); chk("R10 wake irq set", wake_irq, 1);
        step(SU + 2);
        chk("R7 clock after modem wake", clk_en, 1);
        // R8 needs msr read and quiet irq
        rx = 0; step(SU + 8);
        chk("R8 no read, stays awake", bus_iso, 0);
        irq = 1; msr_rd = 1; step(1); msr_rd = 0; step(3);
        chk("R8 irq holds awake", bus_iso, 0);
        irq = 0; step(2);
        chk("R8 auto return", bus_iso, 1);
        // R6 rising rx does not wake; R5 isr ignored
        isr_rd = 1; rx = 1; step(1); isr_rd = 0; step(5);
        chk("R6 rise no wake", bus_iso, 1); chk("R5 wirq kept", wake_irq, 1);
        rx = 0; step(4);
        chk("R6 rx fall wake", osc_en, 1);
        // R11 status read clears
        isr_rd = 1; step(1); isr_rd = 0; step(1);
        chk("R11 read clears", wake_irq, 0);
        step(SU + 2);
        // R9 strap low: leave for good
        psave = 0; step(SU + 10);
        chk("R9 no iso", bus_iso, 0); chk("R9 plain sleep", osc_en, 0);

        // R10 disabled: no request
        wen = 0; rx = 1; step(3); rx = 0; step(4);
        chk("R10 disabled no irq", wake_irq, 0);
        chk("R3 rx wake from sleep", osc_en, 1);
        step(SU + 4);
        wen = 1; modem[0] = 0; step(5);
        chk("R10 enabled sets", wake_irq, 1);
        wen = 0; step(2);
        chk("R11 disable clears", wake_irq, 0);
        step(SU + 4);
        finish_run();
    end
endmodule